// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block decides when a capture instrument has reached its event of interest. Every sample-clock cycle it registers the sampled data bus together with an arm request arriving from a neighbouring capture unit. During the following cycle it evaluates the clauses of its current sequence state against that registered sample. The sequencer has four sequence states, and each state holds two clauses. A clause pairs one condition with one action. The condition can be never, always, a masked equality compare, an inclusive unsigned value range, the event counter having reached its programmed limit, or the external arm input. The action can be none, jump to a state, fire the trigger, increment the counter, clear the counter, or raise the arm output for other units.

Software loads the clause table and the counter limit through a simple write-only register port. It then pulses `arm`. The sequencer has two phases, written `PH_HUNT` and `PH_DONE`. Reset or `arm` puts it in `PH_HUNT`, in sequence state 0, with the counter at zero. There are three phase transitions. First, a clause whose action is fire moves the sequencer from `PH_HUNT` to `PH_DONE`. Second, `PH_DONE` holds itself until `arm`. Third, `arm` returns the sequencer to `PH_HUNT` from either phase. Inside `PH_HUNT`, a jump action moves the sequencer among sequence states 0 to 3. `trig_out` is high exactly while the sequencer is in `PH_DONE`.

Top module: `trig_seq_top`

## Requirements
- R1: After reset, every clause has the never condition. Both outputs are low, the sequencer is in state 0 and the counter is 0.
- R2: Condition code 2 (masked match) is true when `((sample ^ value) & mask) == 0`.
- R3: Condition code 3 (range) is true when `value <= sample <= high`, compared unsigned with both bounds included.
- R4: Condition code 5 is true when the external arm input was high in the evaluated sample. Action code 5 sets `arm_out`, which then stays high until `arm`.
- R5: Condition code 4 is true when counter >= limit. Action code 3 increments the counter, saturating at all ones. Action code 4 clears the counter.
- R6: When several clauses of the current state are true, only the lowest-numbered clause acts. Code 0 is never and code 1 is always. Action code 0 does nothing.
- R7: Action code 1 moves the sequencer to the target state held in control bits [9:8].
- R8: Action code 2 raises `trig_out`. `trig_out` then stays high until `arm`, and while it is high the state and the counter are frozen.
- R9: A sample presented at clock edge k affects the outputs only from edge k+1 onward.
- R10: `arm` returns the sequencer to state 0 with counter 0 and both outputs low. The clause table and the limit are kept.
- R11: The configuration address is {global, slot[2:0], field[1:0]}, where slot = state*2 + clause.
    - Field 0 is the control word: condition in bits [2:0], action in bits [6:4], target in bits [9:8].
    - Field 1 is the value, which also serves as the range low bound.
    - Field 2 is the mask and field 3 is the range high bound.
    - An address with the global bit set writes the counter limit.
    - A write takes effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Restart the sequence and clear the outputs |
| samp_data | input | DATA_W | Sampled data bus |
| ext_arm_in | input | 1 | Arm signal from another capture unit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | SLOT_W+3 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| trig_out | output | 1 | Trigger, held until the next arm |
| arm_out | output | 1 | Arm signal for other units, held until the next arm |

## Verification
Directed sequences try each condition type on its own:
- A masked match checks that masked-off bits are ignored while unmasked bits still count.
- Range values one below the low bound, at both bounds and one above the high bound test inclusive against exclusive bounds.
- A counter sequence tells a limit that has just been reached from one that is one short.
- Two always-true clauses placed in one state separate lowest-clause priority from highest-clause priority, and also show that a jump does not fire the trigger.

Random clause programs driven with a data alphabet of 32 values make hits frequent. These runs compare both outputs on every cycle with a bench model, which exposes off-by-one latency and actions that leak after the trigger has fired.

// File: rtl/trig_seq_pkg.sv
`timescale 1ns/1ps
package trig_seq_pkg;

    // Condition codes for bits [2:0] of a clause control word
    typedef enum logic [2:0] {
        C_NEVER  = 3'd0,
        C_ALWAYS = 3'd1,
        C_MATCH  = 3'd2,
        C_RANGE  = 3'd3,
        C_CNT    = 3'd4,
        C_EXT    = 3'd5
    } cond_e;

    // Action codes for bits [6:4] of a clause control word
    typedef enum logic [2:0] {
        A_NONE = 3'd0,
        A_GOTO = 3'd1,
        A_FIRE = 3'd2,
        A_INC  = 3'd3,
        A_CLR  = 3'd4,
        A_ARMO = 3'd5
    } act_e;

    typedef enum logic {
        PH_HUNT = 1'b0,
        PH_DONE = 1'b1
    } phase_e;

    localparam int CTRL_COND_LSB = 0;
    localparam int CTRL_ACT_LSB  = 4;
    localparam int CTRL_TGT_LSB  = 8;

    localparam logic [1:0] F_CTRL = 2'd0;
    localparam logic [1:0] F_VAL  = 2'd1;
    localparam logic [1:0] F_MASK = 2'd2;
    localparam logic [1:0] F_HIGH = 2'd3;

endpackage

// File: rtl/trig_seq_cfg.sv
`timescale 1ns/1ps
module trig_seq_cfg
    import trig_seq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 16,
    parameter int SLOTS   = 8,
    parameter int SLOT_W  = 3,
    parameter int STATE_W = 2,
    parameter int ADDR_W  = SLOT_W + 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [31:0]                       wdata,
    output logic [SLOTS-1:0][2:0]             cl_cond,
    output logic [SLOTS-1:0][2:0]             cl_act,
    output logic [SLOTS-1:0][STATE_W-1:0]     cl_tgt,
    output logic [SLOTS-1:0][DATA_W-1:0]      cl_val,
    output logic [SLOTS-1:0][DATA_W-1:0]      cl_mask,
    output logic [SLOTS-1:0][DATA_W-1:0]      cl_high,
    output logic [CNT_W-1:0]                  cnt_limit
);

    logic              is_glob;
    logic [SLOT_W-1:0] wslot;
    logic [1:0]        wfield;
    logic              wdata_unused;

    assign is_glob      = addr[ADDR_W-1];
    assign wslot        = addr[ADDR_W-2:2];
    assign wfield       = addr[1:0];
    assign wdata_unused = ^wdata;

    // Counter limit register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_limit <= '0;
        end else if (we && is_glob) begin
            cnt_limit <= wdata[CNT_W-1:0];
        end
    end

    // One register group per clause slot
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit_slot;
        assign hit_slot = we && !is_glob && (wslot == SLOT_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cl_cond[s] <= C_NEVER;
                cl_act[s]  <= A_NONE;
                cl_tgt[s]  <= '0;
                cl_val[s]  <= '0;
                cl_mask[s] <= '0;
                cl_high[s] <= '0;
            end else if (hit_slot) begin
                unique case (wfield)
                    F_CTRL: begin
                        cl_cond[s] <= wdata[CTRL_COND_LSB +: 3];
                        cl_act[s]  <= wdata[CTRL_ACT_LSB +: 3];
                        cl_tgt[s]  <= wdata[CTRL_TGT_LSB +: STATE_W];
                    end
                    F_VAL:   cl_val[s]  <= wdata[DATA_W-1:0];
                    F_MASK:  cl_mask[s] <= wdata[DATA_W-1:0];
                    F_HIGH:  cl_high[s] <= wdata[DATA_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // R11: a control-word write is visible in the next cycle
    a_r11_ctrl_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !is_glob && wfield == F_CTRL)
        |=> (cl_cond[$past(wslot)] == $past(wdata[2:0])
             && cl_act[$past(wslot)] == $past(wdata[6:4])));

    // R11: a limit write is visible in the next cycle
    a_r11_limit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && is_glob) |=> (cnt_limit == $past(wdata[CNT_W-1:0])));

endmodule

// File: rtl/trig_seq_cond.sv
`timescale 1ns/1ps
module trig_seq_cond
    import trig_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        kind,
    input  logic [DATA_W-1:0] val,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] high,
    input  logic [DATA_W-1:0] data,
    input  logic              ext,
    input  logic              cnt_hit,
    output logic              hit
);

    logic match_ok;
    logic range_ok;

    assign match_ok = ((data ^ val) & mask) == '0;
    assign range_ok = (data >= val) && (data <= high);

    always_comb begin
        unique case (cond_e'(kind))
            C_NEVER:  hit = 1'b0;
            C_ALWAYS: hit = 1'b1;
            C_MATCH:  hit = match_ok;
            C_RANGE:  hit = range_ok;
            C_CNT:    hit = cnt_hit;
            C_EXT:    hit = ext;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/trig_seq_fsm.sv
`timescale 1ns/1ps
module trig_seq_fsm
    import trig_seq_pkg::*;
#(
    parameter int NUM_CLAUSES = 2,
    parameter int STATE_W     = 2,
    parameter int CNT_W       = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                arm,
    input  logic [NUM_CLAUSES-1:0]              hit,
    input  logic [NUM_CLAUSES-1:0][2:0]         act,
    input  logic [NUM_CLAUSES-1:0][STATE_W-1:0] tgt,
    output logic [STATE_W-1:0]                  cur_state,
    output logic [CNT_W-1:0]                    cnt_q,
    output logic                                trig_q,
    output logic                                armo_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    phase_e                 phase_q;
    logic [NUM_CLAUSES-1:0] sel_oh;
    logic                   found;
    logic [2:0]             sel_act;
    logic [STATE_W-1:0]     sel_tgt;
    logic                   do_goto;
    logic                   do_fire;
    logic                   do_inc;
    logic                   do_clr;
    logic                   do_armo;

    // Lowest-numbered true clause wins
    always_comb begin
        sel_oh = '0;
        found  = 1'b0;
        for (int i = 0; i < NUM_CLAUSES; i++) begin
            if (hit[i] && !found) begin
                sel_oh[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    always_comb begin
        sel_act = '0;
        sel_tgt = '0;
        for (int i = 0; i < NUM_CLAUSES; i++) begin
            sel_act = sel_act | (act[i] & {3{sel_oh[i]}});
            sel_tgt = sel_tgt | (tgt[i] & {STATE_W{sel_oh[i]}});
        end
    end

    always_comb begin
        do_goto = 1'b0;
        do_fire = 1'b0;
        do_inc  = 1'b0;
        do_clr  = 1'b0;
        do_armo = 1'b0;
        unique case (act_e'(sel_act))
            A_NONE:  ;
            A_GOTO:  do_goto = 1'b1;
            A_FIRE:  do_fire = 1'b1;
            A_INC:   do_inc  = 1'b1;
            A_CLR:   do_clr  = 1'b1;
            A_ARMO:  do_armo = 1'b1;
            default: ;
        endcase
    end

    // State register process: phase, sequence state and counter
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            phase_q   <= PH_HUNT;
            cur_state <= '0;
            cnt_q     <= '0;
        end else begin
            unique case (phase_q)
                PH_HUNT: begin
                    if (do_fire) phase_q <= PH_DONE;
                    if (do_goto) cur_state <= sel_tgt;
                    if (do_inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    if (do_clr) cnt_q <= '0;
                end
                PH_DONE: ;
                default: phase_q <= PH_HUNT;
            endcase
        end
    end

    // Output process: trigger and arm-out levels
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            trig_q <= 1'b0;
            armo_q <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_HUNT: begin
                    if (do_fire) trig_q <= 1'b1;
                    if (do_armo) armo_q <= 1'b1;
                end
                PH_DONE: ;
                default: trig_q <= 1'b0;
            endcase
        end
    end

    // R6: at most one clause is chosen per cycle
    a_r6_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh));

    // R6: a true clause always yields a pick
    a_r6_pick_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> (|sel_oh));

    // R8: trigger holds until arm
    a_r8_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && !arm) |=> trig_q);

    // R8: nothing moves after the trigger
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE && !arm) |=> ($stable(cur_state) && $stable(cnt_q)));

    // R8: trigger level tracks the done phase
    a_r8_trig_phase: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q == (phase_q == PH_DONE));

    // R10: arm restarts everything
    a_r10_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!trig_q && !armo_q && cur_state == '0 && cnt_q == '0));

    // R5: the counter never wraps
    a_r5_cnt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !do_clr) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/trig_seq_top.sv
`timescale 1ns/1ps
module trig_seq_top
    import trig_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int NUM_STATES  = 4,
    parameter int NUM_CLAUSES = 2,
    parameter int CNT_W       = 16,
    localparam int STATE_W    = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1,
    localparam int SLOTS      = NUM_STATES * NUM_CLAUSES,
    localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int ADDR_W     = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [DATA_W-1:0] samp_data,
    input  logic              ext_arm_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              trig_out,
    output logic              arm_out
);

    logic [SLOTS-1:0][2:0]                 cfg_cond;
    logic [SLOTS-1:0][2:0]                 cfg_act;
    logic [SLOTS-1:0][STATE_W-1:0]         cfg_tgt;
    logic [SLOTS-1:0][DATA_W-1:0]          cfg_val;
    logic [SLOTS-1:0][DATA_W-1:0]          cfg_mask;
    logic [SLOTS-1:0][DATA_W-1:0]          cfg_high;
    logic [CNT_W-1:0]                      cnt_limit;

    logic [DATA_W-1:0]                     samp_q;
    logic                                  ext_q;
    logic [STATE_W-1:0]                    cur_state;
    logic [CNT_W-1:0]                      cnt_q;
    logic                                  cnt_hit;
    logic [NUM_CLAUSES-1:0]                cl_hit;
    logic [NUM_CLAUSES-1:0][2:0]           cl_act;
    logic [NUM_CLAUSES-1:0][STATE_W-1:0]   cl_tgt;

    trig_seq_cfg #(
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .SLOTS   (SLOTS),
        .SLOT_W  (SLOT_W),
        .STATE_W (STATE_W),
        .ADDR_W  (ADDR_W)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .cl_cond   (cfg_cond),
        .cl_act    (cfg_act),
        .cl_tgt    (cfg_tgt),
        .cl_val    (cfg_val),
        .cl_mask   (cfg_mask),
        .cl_high   (cfg_high),
        .cnt_limit (cnt_limit)
    );

    // Sample stage: one cycle of latency before evaluation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
            ext_q  <= 1'b0;
        end else begin
            samp_q <= samp_data;
            ext_q  <= ext_arm_in;
        end
    end

    assign cnt_hit = (cnt_q >= cnt_limit);

    // One evaluator per clause of the current state
    for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_clause
        logic [SLOT_W-1:0] slot_idx;
        assign slot_idx  = SLOT_W'(int'(cur_state) * NUM_CLAUSES + c);
        assign cl_act[c] = cfg_act[slot_idx];
        assign cl_tgt[c] = cfg_tgt[slot_idx];

        trig_seq_cond #(
            .DATA_W (DATA_W)
        ) i_cond (
            .kind    (cfg_cond[slot_idx]),
            .val     (cfg_val[slot_idx]),
            .mask    (cfg_mask[slot_idx]),
            .high    (cfg_high[slot_idx]),
            .data    (samp_q),
            .ext     (ext_q),
            .cnt_hit (cnt_hit),
            .hit     (cl_hit[c])
        );
    end

    trig_seq_fsm #(
        .NUM_CLAUSES (NUM_CLAUSES),
        .STATE_W     (STATE_W),
        .CNT_W       (CNT_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .hit       (cl_hit),
        .act       (cl_act),
        .tgt       (cl_tgt),
        .cur_state (cur_state),
        .cnt_q     (cnt_q),
        .trig_q    (trig_out),
        .armo_q    (arm_out)
    );

    // R9: the trigger can only rise one edge after a sample is taken
    a_r9_no_early_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_out && !arm && $stable(samp_q) && (cl_hit == '0)) |=> !trig_out);

endmodule

// File: tb/test_trig_seq_top.sv
`timescale 1ns/1ps
module test_trig_seq_top;

    localparam int DW = 16;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          arm;
    logic [DW-1:0] samp_data;
    logic          ext_arm_in;
    logic          cfg_we;
    logic [AW-1:0] cfg_addr;
    logic [31:0]   cfg_wdata;
    logic          trig_out;
    logic          arm_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model state
    int          m_cond [8];
    int          m_act  [8];
    int          m_tgt  [8];
    logic [15:0] m_val  [8];
    logic [15:0] m_mask [8];
    logic [15:0] m_high [8];
    logic [15:0] m_lim;
    logic [15:0] m_samp;
    logic        m_ext;
    int          m_state;
    logic [15:0] m_cnt;
    bit          m_trig;
    bit          m_armo;

    always #5 clk = ~clk;

    trig_seq_top i_trig_seq_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .samp_data  (samp_data),
        .ext_arm_in (ext_arm_in),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .trig_out   (trig_out),
        .arm_out    (arm_out)
    );

    function automatic bit cond_true(int s);
        case (m_cond[s])
            0:       return 1'b0;
            1:       return 1'b1;
            2:       return ((m_samp ^ m_val[s]) & m_mask[s]) == 16'h0;
            3:       return (m_samp >= m_val[s]) && (m_samp <= m_high[s]);
            4:       return m_cnt >= m_lim;
            5:       return m_ext;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ctrl(int c, int a, int t);
        return 32'((t << 8) | (a << 4) | c);
    endfunction

    task automatic check(bit act, bit exp, string tag, string what);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One sample cycle: drive, advance the model, compare both outputs
    task automatic step(logic [15:0] d, bit ext, bit a, bit we,
                        logic [5:0] ad, logic [31:0] wd, string tag);
        @(negedge clk);
        samp_data  = d;
        ext_arm_in = ext;
        arm        = a;
        cfg_we     = we;
        cfg_addr   = ad;
        cfg_wdata  = wd;
        @(posedge clk);
        if (a) begin
            m_state = 0; m_cnt = 0; m_trig = 0; m_armo = 0;
        end else if (!m_trig) begin
            int pick = -1;
            for (int c = 1; c >= 0; c--) begin
                if (cond_true(m_state * 2 + c)) pick = m_state * 2 + c;
            end
            if (pick >= 0) begin
                case (m_act[pick])
                    1: m_state = m_tgt[pick];
                    2: m_trig = 1;
                    3: if (m_cnt != 16'hFFFF) m_cnt = m_cnt + 16'd1;
                    4: m_cnt = 0;
                    5: m_armo = 1;
                    default: ;
                endcase
            end
        end
        if (we) begin
            if (ad[5]) m_lim = wd[15:0];
            else begin
                int s = int'(ad[4:2]);
                case (ad[1:0])
                    2'd0: begin
                        m_cond[s] = int'(wd[2:0]);
                        m_act[s]  = int'(wd[6:4]);
                        m_tgt[s]  = int'(wd[9:8]);
                    end
                    2'd1: m_val[s]  = wd[15:0];
                    2'd2: m_mask[s] = wd[15:0];
                    default: m_high[s] = wd[15:0];
                endcase
            end
        end
        m_samp = d;
        m_ext  = ext;
        #2;
        check(trig_out, m_trig, tag, "trig_out");
        check(arm_out, m_armo, tag, "arm_out");
    endtask

    task automatic dat(logic [15:0] d, string tag);
        step(d, 1'b0, 1'b0, 1'b0, 6'd0, 32'd0, tag);
    endtask

    task automatic do_arm();
        step(16'd0, 1'b0, 1'b1, 1'b0, 6'd0, 32'd0, "R10");
    endtask

    task automatic cw(int slot, int field, logic [31:0] wd);
        step(16'd0, 1'b0, 1'b0, 1'b1, 6'((slot << 2) | field), wd, "R11");
    endtask

    task automatic clear_prog();
        for (int s = 0; s < 8; s++) cw(s, 0, 32'd0);
    endtask

    initial begin
        #(1_500_000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; arm = 0; samp_data = 0; ext_arm_in = 0;
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        for (int s = 0; s < 8; s++) begin
            m_cond[s] = 0; m_act[s] = 0; m_tgt[s] = 0;
            m_val[s] = 0; m_mask[s] = 0; m_high[s] = 0;
        end
        m_lim = 0; m_samp = 0; m_ext = 0; m_state = 0;
        m_cnt = 0; m_trig = 0; m_armo = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check(trig_out, 1'b0, "R1", "trig_out after reset");
        check(arm_out, 1'b0, "R1", "arm_out after reset");
        dat(16'hFFFF, "R1");
        check(trig_out, 1'b0, "R1", "idle with never clauses");

        // R2: masked match, high byte only
        cw(0, 0, ctrl(2, 2, 0));
        cw(0, 1, 32'h1234);
        cw(0, 2, 32'hFF00);
        do_arm();
        dat(16'h13AB, "R2");
        dat(16'h12AB, "R2");
        check(trig_out, 1'b0, "R9", "no fire on the sampling edge");
        dat(16'h0000, "R2");
        check(trig_out, 1'b1, "R2", "masked match fires");
        dat(16'h5555, "R8");
        check(trig_out, 1'b1, "R8", "trigger held");

        // R3: inclusive range bounds
        cw(0, 0, ctrl(3, 2, 0));
        cw(0, 1, 32'h0010);
        cw(0, 3, 32'h0020);
        do_arm();
        dat(16'h000F, "R3");
        dat(16'h0021, "R3");
        dat(16'h0000, "R3");
        check(trig_out, 1'b0, "R3", "outside range ignored");
        dat(16'h0020, "R3");
        dat(16'h0000, "R3");
        check(trig_out, 1'b1, "R3", "high bound included");
        do_arm();
        check(trig_out, 1'b0, "R10", "arm clears trigger");
        dat(16'h0010, "R3");
        dat(16'h0000, "R3");
        check(trig_out, 1'b1, "R3", "low bound included");

        // R4: external arm condition raises arm_out
        clear_prog();
        cw(0, 0, ctrl(5, 5, 0));
        do_arm();
        step(16'd0, 1'b1, 1'b0, 1'b0, 6'd0, 32'd0, "R4");
        dat(16'd0, "R4");
        check(arm_out, 1'b1, "R4", "arm_out from ext arm");
        check(trig_out, 1'b0, "R4", "no trigger from arm action");

        // R5: count three matches then fire
        clear_prog();
        cw(0, 0, ctrl(4, 2, 0));
        cw(1, 0, ctrl(2, 3, 0));
        cw(1, 1, 32'h0007);
        cw(1, 2, 32'hFFFF);
        step(16'd0, 1'b0, 1'b0, 1'b1, 6'd32, 32'd3, "R11");
        do_arm();
        dat(16'h0007, "R5"); dat(16'h0001, "R5");
        dat(16'h0007, "R5"); dat(16'h0007, "R5");
        dat(16'h0001, "R5");
        check(trig_out, 1'b0, "R5", "limit not yet seen");
        dat(16'h0001, "R5");
        check(trig_out, 1'b1, "R5", "limit reached fires");

        // R6 and R7: priority and jumps
        clear_prog();
        cw(0, 0, ctrl(1, 1, 2));
        cw(1, 0, ctrl(1, 2, 0));
        cw(4, 0, ctrl(2, 2, 0));
        cw(4, 1, 32'hAAAA);
        cw(4, 2, 32'hFFFF);
        do_arm();
        dat(16'h0000, "R6"); dat(16'h0000, "R6"); dat(16'h0000, "R6");
        check(trig_out, 1'b0, "R6", "lower clause wins over fire");
        dat(16'hAAAA, "R7");
        dat(16'h0000, "R7");
        check(trig_out, 1'b1, "R7", "fire after jump to state 2");

        // Random programs compared cycle by cycle
        for (int r = 0; r < 40; r++) begin
            for (int s = 0; s < 8; s++) begin
                int v = int'($urandom % 32);
                cw(s, 0, ctrl(int'($urandom % 6), int'($urandom % 6), int'($urandom % 4)));
                cw(s, 1, 32'(v));
                cw(s, 2, 32'($urandom % 32));
                cw(s, 3, 32'(v + int'($urandom % 16)));
            end
            step(16'd0, 1'b0, 1'b0, 1'b1, 6'd32, 32'($urandom % 6), "R5");
            do_arm();
            for (int k = 0; k < 200; k++) begin
                step(16'($urandom % 32), ($urandom % 8) == 0,
                     ($urandom % 60) == 0, 1'b0, 6'd0, 32'd0, "R9");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule